// File: doc/BRIEF.md
# Conditional Data-Processing ALU

This block is the arithmetic and logic stage of a processor whose instructions all carry a 4-bit condition field. Each cycle it may accept one instruction. An instruction arrives as a 4-bit opcode, an S bit, a condition field and two operands. The second operand has already been through the barrel shifter, and the shifter's carry-out comes with it. The current NZCV flags arrive on the same cycle.

The block tests the condition against the flags to decide whether the instruction takes effect. It computes one of sixteen operations and works out the new flags under rules that depend on the operation class. It then states whether the destination register and the flags register are to be written.

All outputs are registered and appear one clock after the instruction is accepted. The register file, the shifter and the flag register itself belong to other blocks.

Top module: `alu_core`

## Requirements
- R1: An instruction presented with `inValid` high produces its outputs one clock later, with `outValid` high. A cycle with `inValid` low gives `outValid`, `executed`, `regWrite` and `flagsWrite` all low on the next cycle.
- R2: While `rstN` is low, every output is zero.
- R3: `executed` follows the condition field against `flagsIn`, where `flagsIn`/`flagsOut` are {N,Z,C,V} in bits 3..0. The codes are: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 (N==V)&!Z; 13 (N!=V)|Z; 14 always; 15 never.
- R4: The arithmetic opcodes compute, modulo 2^W: 2 A-B; 3 B-A; 4 A+B; 5 A+B+C; 6 A-B-(1-C); 7 B-A-(1-C); 10 as 2; 11 as 4. Here A is `opA`, B is `opB` and C is the incoming carry flag.
- R5: The logical opcodes compute: 0 A&B; 1 A^B; 8 as 0; 9 as 1; 12 A|B; 13 B; 14 A&~B; 15 ~B.
- R6: For arithmetic opcodes, C is the adder carry-out, which is the inverted borrow for subtraction (1 when no borrow occurs). V is set on two's-complement overflow.
- R7: For logical opcodes, C takes `shCarry` and V keeps its incoming value.
- R8: When flags are written, N is the top bit of the result and Z is set when the result is zero.
- R9: The compare opcodes 8, 9, 10 and 11 never assert `regWrite`. When they execute they always write flags, whatever S is.
- R10: With S low, a non-compare opcode does not assert `flagsWrite`. Whenever `flagsWrite` is low, `flagsOut` equals the incoming flags.
- R11: A skipped instruction (condition false) asserts neither `regWrite` nor `flagsWrite`, and its `flagsOut` equals the incoming flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction present this cycle |
| opA | input | DATA_W | First operand |
| opB | input | DATA_W | Shifted second operand |
| shCarry | input | 1 | Shifter carry-out |
| opcode | input | 4 | Operation select |
| setFlags | input | 1 | S bit |
| condCode | input | 4 | Condition field |
| flagsIn | input | 4 | Current flags {N,Z,C,V} |
| outValid | output | 1 | Outputs belong to an accepted instruction |
| executed | output | 1 | Condition held |
| regWrite | output | 1 | Destination write enable |
| flagsWrite | output | 1 | Flag register write enable |
| result | output | DATA_W | Operation result |
| flagsOut | output | 4 | Flags to store {N,Z,C,V} |

## Verification
Every result, flag and strobe is due exactly one rising edge after its instruction is applied. The bench drives each instruction on a falling edge, lets one rising edge pass, and compares all outputs on the next falling edge before it drives the next instruction. This keeps checks one-to-one with stimuli even though `inValid` stays high throughout the sweep. The sweep is exhaustive over opcode, condition, flags and S on an 8-bit build, with a set of carry, overflow and zero corner operands. The idle cycle after the sweep and the reset state are each checked on the cycle their value is due.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } aluOp_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
  } cond_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } carrySel_e;

  typedef enum logic [2:0] {
    LG_AND  = 3'd0,
    LG_EOR  = 3'd1,
    LG_ORR  = 3'd2,
    LG_PASS = 3'd3,
    LG_BIC  = 3'd4,
    LG_NOT  = 3'd5
  } logicSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      arith;
    logic      swapOps;
    logic      invY;
    carrySel_e cinSel;
    logicSel_e lgSel;
  } dpStrobe_t;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0] opcode,
  input  logic       setFlags,
  input  logic [3:0] condCode,
  input  logic [3:0] flagsIn,
  output dpStrobe_t  dpStrobe,
  output logic       execute,
  output logic       writeRes,
  output logic       writeFlags
);

  logic fN, fZ, fC, fV;
  logic isCompare;

  assign fN = flagsIn[FLAG_N];
  assign fZ = flagsIn[FLAG_Z];
  assign fC = flagsIn[FLAG_C];
  assign fV = flagsIn[FLAG_V];

  always_comb begin
    unique case (cond_e'(condCode))
      CC_EQ: execute = fZ;
      CC_NE: execute = !fZ;
      CC_CS: execute = fC;
      CC_CC: execute = !fC;
      CC_MI: execute = fN;
      CC_PL: execute = !fN;
      CC_VS: execute = fV;
      CC_VC: execute = !fV;
      CC_HI: execute = fC && !fZ;
      CC_LS: execute = !fC || fZ;
      CC_GE: execute = (fN == fV);
      CC_LT: execute = (fN != fV);
      CC_GT: execute = (fN == fV) && !fZ;
      CC_LE: execute = (fN != fV) || fZ;
      CC_AL: execute = 1'b1;
      default: execute = 1'b0;
    endcase
  end

  always_comb begin
    dpStrobe = '{arith: 1'b0, swapOps: 1'b0, invY: 1'b0,
                 cinSel: CIN_ZERO, lgSel: LG_AND};
    unique case (aluOp_e'(opcode))
      OP_AND, OP_TST: dpStrobe.lgSel = LG_AND;
      OP_EOR, OP_TEQ: dpStrobe.lgSel = LG_EOR;
      OP_ORR:         dpStrobe.lgSel = LG_ORR;
      OP_MOV:         dpStrobe.lgSel = LG_PASS;
      OP_BIC:         dpStrobe.lgSel = LG_BIC;
      OP_MVN:         dpStrobe.lgSel = LG_NOT;
      OP_SUB, OP_CMP: begin
        dpStrobe.arith  = 1'b1;
        dpStrobe.invY   = 1'b1;
        dpStrobe.cinSel = CIN_ONE;
      end
      OP_RSB: begin
        dpStrobe.arith   = 1'b1;
        dpStrobe.swapOps = 1'b1;
        dpStrobe.invY    = 1'b1;
        dpStrobe.cinSel  = CIN_ONE;
      end
      OP_ADD, OP_CMN: dpStrobe.arith = 1'b1;
      OP_ADC: begin
        dpStrobe.arith  = 1'b1;
        dpStrobe.cinSel = CIN_FLAG;
      end
      OP_SBC: begin
        dpStrobe.arith  = 1'b1;
        dpStrobe.invY   = 1'b1;
        dpStrobe.cinSel = CIN_FLAG;
      end
      default: begin // OP_RSC
        dpStrobe.arith   = 1'b1;
        dpStrobe.swapOps = 1'b1;
        dpStrobe.invY    = 1'b1;
        dpStrobe.cinSel  = CIN_FLAG;
      end
    endcase
  end

  assign isCompare  = (opcode[3:2] == 2'b10);
  assign writeRes   = execute && !isCompare;
  assign writeFlags = execute && (setFlags || isCompare);

endmodule

// File: rtl/alu_dpath.sv
module alu_dpath
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              shCarry,
  input  logic              carryIn,
  input  logic              ovfIn,
  input  dpStrobe_t         dpStrobe,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        newFlags
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] addX, addYRaw, addY, logicRes;
  logic [DATA_W:0]   sum;
  logic              cin, cOut, vOut;

  assign addX    = dpStrobe.swapOps ? opB : opA;
  assign addYRaw = dpStrobe.swapOps ? opA : opB;
  assign addY    = dpStrobe.invY ? ~addYRaw : addYRaw;

  always_comb begin
    unique case (dpStrobe.cinSel)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = carryIn;
      default:  cin = 1'b0;
    endcase
  end

  assign sum = {1'b0, addX} + {1'b0, addY} + {{DATA_W{1'b0}}, cin};

  always_comb begin
    unique case (dpStrobe.lgSel)
      LG_AND:  logicRes = opA & opB;
      LG_EOR:  logicRes = opA ^ opB;
      LG_ORR:  logicRes = opA | opB;
      LG_PASS: logicRes = opB;
      LG_BIC:  logicRes = opA & ~opB;
      default: logicRes = ~opB;
    endcase
  end

  assign result = dpStrobe.arith ? sum[DATA_W-1:0] : logicRes;
  assign cOut   = dpStrobe.arith ? sum[DATA_W] : shCarry;
  assign vOut   = dpStrobe.arith ?
                  ((addX[MSB] == addY[MSB]) && (sum[MSB] != addX[MSB])) : ovfIn;

  always_comb begin
    newFlags         = '0;
    newFlags[FLAG_N] = result[MSB];
    newFlags[FLAG_Z] = (result == '0);
    newFlags[FLAG_C] = cOut;
    newFlags[FLAG_V] = vOut;
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              shCarry,
  input  logic [3:0]        opcode,
  input  logic              setFlags,
  input  logic [3:0]        condCode,
  input  logic [3:0]        flagsIn,
  output logic              outValid,
  output logic              executed,
  output logic              regWrite,
  output logic              flagsWrite,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flagsOut
);

  dpStrobe_t         dpStrobe;
  logic              execute, writeRes, writeFlags;
  logic [DATA_W-1:0] dpResult;
  logic [3:0]        newFlags;

  alu_ctrl uCtrl (
    .opcode     (opcode),
    .setFlags   (setFlags),
    .condCode   (condCode),
    .flagsIn    (flagsIn),
    .dpStrobe   (dpStrobe),
    .execute    (execute),
    .writeRes   (writeRes),
    .writeFlags (writeFlags)
  );

  alu_dpath #(.DATA_W(DATA_W)) uDpath (
    .opA      (opA),
    .opB      (opB),
    .shCarry  (shCarry),
    .carryIn  (flagsIn[FLAG_C]),
    .ovfIn    (flagsIn[FLAG_V]),
    .dpStrobe (dpStrobe),
    .result   (dpResult),
    .newFlags (newFlags)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      executed   <= 1'b0;
      regWrite   <= 1'b0;
      flagsWrite <= 1'b0;
      result     <= '0;
      flagsOut   <= '0;
    end else if (inValid) begin
      outValid   <= 1'b1;
      executed   <= execute;
      regWrite   <= writeRes;
      flagsWrite <= writeFlags;
      result     <= dpResult;
      flagsOut   <= writeFlags ? newFlags : flagsIn;
    end else begin
      outValid   <= 1'b0;
      executed   <= 1'b0;
      regWrite   <= 1'b0;
      flagsWrite <= 1'b0;
    end
  end

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic [3:0] opcode,
  input logic [3:0] condCode,
  input logic [3:0] flagsIn,
  input logic       outValid,
  input logic       executed,
  input logic       regWrite,
  input logic       flagsWrite,
  input logic [3:0] flagsOut
);

  logic isCmp, isLogic;
  assign isCmp   = (opcode[3:2] == 2'b10);
  assign isLogic = opcode[3] ? (opcode[2] || !opcode[1]) : (opcode[2:1] == 2'b00);

  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !executed && !regWrite && !flagsWrite));

  p_never_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && condCode == 4'hF) |=> !executed);

  p_always_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && condCode == 4'hE) |=> executed);

  p_cmp_nowrite_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isCmp) |=> !regWrite);

  p_cmp_flags_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isCmp && condCode == 4'hE) |=> flagsWrite);

  p_hold_flags_r10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (flagsWrite || flagsOut == $past(flagsIn)));

  p_logic_v_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isLogic) |=> (flagsOut[0] == $past(flagsIn[0])));

  p_skip_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !executed |-> (!regWrite && !flagsWrite));

endmodule

bind alu_core alu_core_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .opcode     (opcode),
  .condCode   (condCode),
  .flagsIn    (flagsIn),
  .outValid   (outValid),
  .executed   (executed),
  .regWrite   (regWrite),
  .flagsWrite (flagsWrite),
  .flagsOut   (flagsOut)
);

// File: tb/sim_alu_core.sv
`timescale 1ns/1ps
module sim_alu_core;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         shCarry = 1'b0;
  logic [3:0]   opcode = '0;
  logic         setFlags = 1'b0;
  logic [3:0]   condCode = '0;
  logic [3:0]   flagsIn = '0;
  logic         outValid, executed, regWrite, flagsWrite;
  logic [W-1:0] result;
  logic [3:0]   flagsOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  alu_core #(.DATA_W(W)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .shCarry(shCarry), .opcode(opcode), .setFlags(setFlags),
    .condCode(condCode), .flagsIn(flagsIn), .outValid(outValid),
    .executed(executed), .regWrite(regWrite), .flagsWrite(flagsWrite),
    .result(result), .flagsOut(flagsOut)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit condTrue(input logic [3:0] cc, input logic [3:0] f);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return (n == v) && !z;
      4'd13: return (n != v) || z;
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int toSigned(input logic [W-1:0] x);
    return x[W-1] ? int'(x) - (1 << W) : int'(x);
  endfunction

  // expected result and freshly computed flags {N,Z,C,V}
  task automatic model(input logic [3:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input bit shc, input logic [3:0] f,
                       output logic [W-1:0] r, output logic [3:0] nf);
    int ua = int'(a), ub = int'(b);
    int sa = toSigned(a), sb = toSigned(b);
    int c = int'(f[1]);
    int full = 0, sres = 0;
    bit cy = 1'b0, isArith = 1'b1;
    case (op)
      4'd2, 4'd10: begin full = ua - ub; cy = (ua >= ub); sres = sa - sb; end
      4'd3: begin full = ub - ua; cy = (ub >= ua); sres = sb - sa; end
      4'd4, 4'd11: begin full = ua + ub; cy = (full >= (1 << W)); sres = sa + sb; end
      4'd5: begin full = ua + ub + c; cy = (full >= (1 << W)); sres = sa + sb + c; end
      4'd6: begin full = ua - ub - (1 - c); cy = (ua >= ub + 1 - c); sres = sa - sb - (1 - c); end
      4'd7: begin full = ub - ua - (1 - c); cy = (ub >= ua + 1 - c); sres = sb - sa - (1 - c); end
      default: isArith = 1'b0;
    endcase
    if (isArith) begin
      r = full[W-1:0];
      nf = {r[W-1], r == '0, cy, (sres > (1 << (W-1)) - 1) || (sres < -(1 << (W-1)))};
    end else begin
      case (op)
        4'd0, 4'd8:  r = a & b;
        4'd1, 4'd9:  r = a ^ b;
        4'd12:       r = a | b;
        4'd13:       r = b;
        4'd14:       r = a & ~b;
        default:     r = ~b;
      endcase
      nf = {r[W-1], r == '0, shc, f[0]};
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pa [6] = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h35, 8'h01};
    logic [W-1:0] pb [6] = '{8'h00, 8'h01, 8'h80, 8'h01, 8'hA2, 8'hFF};

    // R2: reset state
    repeat (3) @(negedge clk);
    chk({outValid, executed, regWrite, flagsWrite} == 4'b0, "R2", "strobes in reset",
        {28'b0, outValid, executed, regWrite, flagsWrite}, 32'h0);
    chk(result == '0 && flagsOut == '0, "R2", "result/flags in reset",
        {20'b0, result, flagsOut}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int op = 0; op < 16; op++)
      for (int cc = 0; cc < 16; cc++)
        for (int fl = 0; fl < 16; fl++)
          for (int s = 0; s < 2; s++)
            for (int p = 0; p < 6; p++) begin
              logic [W-1:0] expR;
              logic [3:0]   newF, expF;
              bit expEx, isCmp, expRw, expFw, shc;
              shc = p[0];
              model(op[3:0], pa[p], pb[p], shc, fl[3:0], expR, newF);
              expEx = condTrue(cc[3:0], fl[3:0]);
              isCmp = (op >= 8) && (op <= 11);
              expRw = expEx && !isCmp;
              expFw = expEx && (s == 1 || isCmp);
              expF  = expFw ? newF : fl[3:0];
              opA = pa[p]; opB = pb[p]; shCarry = shc;
              opcode = op[3:0]; condCode = cc[3:0]; flagsIn = fl[3:0];
              setFlags = s[0]; inValid = 1'b1;
              @(negedge clk);
              chk(outValid == 1'b1, "R1", "outValid", {31'b0, outValid}, 32'h1);
              chk(executed == expEx, "R3", "executed", {31'b0, executed}, {31'b0, expEx});
              chk(result == expR, (op >= 2 && op <= 7) || op == 10 || op == 11 ? "R4" : "R5",
                  "result", {24'b0, result}, {24'b0, expR});
              chk(regWrite == expRw, expEx ? "R9" : "R11", "regWrite",
                  {31'b0, regWrite}, {31'b0, expRw});
              chk(flagsWrite == expFw, isCmp ? "R9" : (expEx ? "R10" : "R11"), "flagsWrite",
                  {31'b0, flagsWrite}, {31'b0, expFw});
              // R6 R7 R8: new flags; R10 R11: held flags
              chk(flagsOut == expF, expFw ? "R6/R7/R8" : "R10/R11", "flagsOut",
                  {28'b0, flagsOut}, {28'b0, expF});
            end

    // R1: idle cycle
    inValid = 1'b0;
    @(negedge clk);
    chk({outValid, executed, regWrite, flagsWrite} == 4'b0, "R1", "idle strobes",
        {28'b0, outValid, executed, regWrite, flagsWrite}, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule